// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block keeps the interrupt enable and interrupt flag registers of a USB device controller and produces one interrupt request line for the CPU. Eight event sources feed it: bus reset done, VBUS present, VBUS absent, suspend, bus reset, bus activity, remote wake-up done and D+ activity. Each event arrives as a one-cycle pulse and sets a sticky flag. Each flag has a matching enable bit. The request is raised when any flag and its enable are both set.

The CPU reaches both registers over a simple register bus with a 5-bit address. Access works only while the USB enable input is high. A bus reset event also changes the enable register by hardware. It forces the bus-reset enable on, keeps the bus-reset-done enable, and clears every other enable.

The address decoder sorts each access into one of three selections: `SEL_NONE` (no register, or access blocked), `SEL_ENABLE` and `SEL_FLAG`. The block has no other sequencing state.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After reset, the enable register (04h) and the flag register (05h) both read 00h, and `irq` is 0.
- R2: Address 04h selects the 8-bit enable register and address 05h selects the 8-bit flag register. Both are read/write, and `reg_rdata` is combinational. Any other address reads 00h.
- R3: While `usb_en` is 0, reads return 00h and writes change nothing. The stored contents are kept and read back unchanged once `usb_en` returns to 1.
- R4: A pulse on event bit 3 (bus reset) has these effects on the enable register at the next edge:
  - bits 6, 5, 4, 2, 1 and 0 clear;
  - bit 7 keeps its value;
  - bit 3 becomes 1;
  - this action wins over a software write to 04h in the same cycle.
- R5: A flag bit, once set, stays set until software writes 0 to it at address 05h.
- R6: An event pulse on `evt_pulse[i]` sets flag bit i, and the event wins over a same-cycle software clear of that bit. From bit 7 down to bit 0 the events are: bus reset done, VBUS present, VBUS absent, suspend, bus reset, bus activity, remote wake-up done, D+ activity.
- R7: Software writing 1 to a flag bit sets it.
- R8: `irq` is a register. At each edge it takes the OR over all bits of (flag AND enable) as they stood before that edge, so it follows a register change by one clock.
- R9: Event pulses set flags whatever the value of `usb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_en | input | 1 | Register access gate |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag bit |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 5-bit address, enable at 04h and flags at 05h, the bus-reset bit at 3 and the held bit at 7. These values place the hold, force and clear behaviour of R4 on exactly the bits named in the requirements. They also make the address decode cover an out-of-range address (06h) and the two register addresses. Collisions in the same cycle are exercised directly: a bus reset against an enable write, and an event against a flag clear. Access blocked by `usb_en` is checked by reading the registers back after it is released.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_FLAG   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/usb_irq_decode.sv
module usb_irq_decode
    import usb_irq_pkg::*;
#(
    parameter int          ADDR_W      = 5,
    parameter logic [4:0]  ENABLE_ADDR = 5'h04,
    parameter logic [4:0]  FLAG_ADDR   = 5'h05
) (
    input  logic              usb_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    output reg_sel_e          sel,
    output logic              wr_enable,
    output logic              wr_flag
);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_ADDR);
    localparam logic [ADDR_W-1:0] FL_A = ADDR_W'(FLAG_ADDR);

    always_comb begin
        if (!usb_en)               sel = SEL_NONE;
        else if (reg_addr == EN_A) sel = SEL_ENABLE;
        else if (reg_addr == FL_A) sel = SEL_FLAG;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        wr_enable = 1'b0;
        wr_flag   = 1'b0;
        unique case (sel)
            SEL_ENABLE: wr_enable = reg_wr;
            SEL_FLAG:   wr_flag   = reg_wr;
            default:    ;
        endcase
    end
endmodule

// File: rtl/usb_irq_enable_bank.sv
module usb_irq_enable_bank #(
    parameter int DATA_W   = 8,
    parameter int BRST_BIT = 3,
    parameter int HOLD_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              brst_evt,
    output logic [DATA_W-1:0] en_q
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << BRST_BIT) | (DATA_W'(1) << HOLD_BIT);

    logic [DATA_W-1:0] hw_val;

    // per-bit hardware action on bus reset
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == BRST_BIT) begin : g_force
            assign hw_val[b] = 1'b1;
        end else if (b == HOLD_BIT) begin : g_hold
            assign hw_val[b] = en_q[b];
        end else begin : g_clear
            assign hw_val[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        en_q <= '0;
        else if (brst_evt) en_q <= hw_val;
        else if (wr)       en_q <= wdata;
    end

    AST_BRST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        brst_evt |=> en_q[BRST_BIT] && ((en_q & ~KEEP_MASK) == '0)); // R4
    AST_BRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        brst_evt |=> en_q[HOLD_BIT] == $past(en_q[HOLD_BIT])); // R4
endmodule

// File: rtl/usb_irq_flag_bank.sv
module usb_irq_flag_bank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] flag_q
);
    logic [DATA_W-1:0] sw_val;

    assign sw_val = wr ? wdata : flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= sw_val | evt;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt))); // R6
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         ADDR_W      = 5,
    parameter logic [4:0] ENABLE_ADDR = 5'h04,
    parameter logic [4:0] FLAG_ADDR   = 5'h05,
    parameter int         BRST_BIT    = 3,
    parameter int         HOLD_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] evt_pulse,
    output logic              irq
);
    reg_sel_e          sel;
    logic              wr_enable;
    logic              wr_flag;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] flag_q;

    usb_irq_decode #(
        .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR), .FLAG_ADDR(FLAG_ADDR)
    ) i_decode (
        .usb_en(usb_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .sel(sel), .wr_enable(wr_enable), .wr_flag(wr_flag)
    );

    usb_irq_enable_bank #(
        .DATA_W(DATA_W), .BRST_BIT(BRST_BIT), .HOLD_BIT(HOLD_BIT)
    ) i_enable (
        .clk(clk), .rst_n(rst_n), .wr(wr_enable), .wdata(reg_wdata),
        .brst_evt(evt_pulse[BRST_BIT]), .en_q(en_q)
    );

    usb_irq_flag_bank #(.DATA_W(DATA_W)) i_flag (
        .clk(clk), .rst_n(rst_n), .wr(wr_flag), .wdata(reg_wdata),
        .evt(evt_pulse), .flag_q(flag_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ENABLE: reg_rdata = en_q;
            SEL_FLAG:   reg_rdata = flag_q;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_q & en_q);
    end

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(flag_q & en_q))); // R8
    AST_NO_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!usb_en && !evt_pulse[BRST_BIT]) |=> $stable(en_q)); // R3
    AST_RD_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_en |-> reg_rdata == '0); // R3
endmodule

// File: tb/test_usb_irq_ctrl.sv
module test_usb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_en = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] evt_pulse = '0;
    logic       irq;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    bit    chk_pending = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    usb_irq_ctrl i_usb_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .usb_en(usb_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (chk_pending && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'd0, irq} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%02h expected=%02h", it.req, act, it.exp);
            end
            chk_pending = 1'b0;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [7:0] e, input string r);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.req = r;
        sb_q.push_back(it);
        chk_pending = 1'b1;
        tick();
    endtask

    task automatic expect_irq(input bit e, input string r);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'd0, e}; it.req = r;
        sb_q.push_back(it);
        chk_pending = 1'b1;
        tick();
    endtask

    task automatic wr_evt(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_pulse = ev;
        tick();
        reg_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        evt_pulse = ev;
        tick();
        evt_pulse = '0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        usb_en = 1'b1;
        tick();
        // R1 reset state
        expect_rd(5'h04, 8'h00, "R1 enable reset");
        expect_rd(5'h05, 8'h00, "R1 flag reset");
        expect_irq(1'b0, "R1 irq reset");
        // R2 enable register read/write and decode
        wr_evt(5'h04, 8'hA5, 8'h00);
        expect_rd(5'h04, 8'hA5, "R2 enable rw");
        wr_evt(5'h06, 8'hFF, 8'h00);
        expect_rd(5'h06, 8'h00, "R2 unmapped read");
        expect_rd(5'h04, 8'hA5, "R2 unmapped write ignored");
        // R7 software set, R8 irq
        wr_evt(5'h05, 8'h3C, 8'h00);
        expect_rd(5'h05, 8'h3C, "R7 flag write set");
        expect_irq(1'b1, "R8 irq on flag&enable");
        wr_evt(5'h05, 8'h00, 8'h00);
        expect_rd(5'h05, 8'h00, "R5 software clear");
        expect_irq(1'b0, "R8 irq drops");
        // R6 event sets flag, R5 sticky
        pulse(8'h02);
        expect_rd(5'h05, 8'h02, "R6 event sets flag");
        tick(); tick(); tick();
        expect_rd(5'h05, 8'h02, "R5 flag sticky");
        expect_irq(1'b0, "R8 disabled flag no irq");
        // R3 gating
        usb_en = 1'b0;
        expect_rd(5'h04, 8'h00, "R3 read gated");
        wr_evt(5'h04, 8'hFF, 8'h00);
        wr_evt(5'h05, 8'h00, 8'h00);
        usb_en = 1'b1;
        expect_rd(5'h04, 8'hA5, "R3 enable write ignored");
        expect_rd(5'h05, 8'h02, "R3 flag write ignored");
        // R4 bus reset on enable A5 -> 88
        pulse(8'h08);
        expect_rd(5'h04, 8'h88, "R4 bus reset enables");
        // R4 priority over write, bit7 previously 0
        wr_evt(5'h04, 8'h00, 8'h00);
        wr_evt(5'h04, 8'hFF, 8'h08);
        expect_rd(5'h04, 8'h08, "R4 bus reset beats write");
        // R6 event beats clear
        wr_evt(5'h05, 8'h00, 8'h10);
        expect_rd(5'h05, 8'h10, "R6 event beats clear");
        expect_irq(1'b0, "R8 flag10 enable08");
        // R9 event while access gated
        usb_en = 1'b0;
        pulse(8'h01);
        usb_en = 1'b1;
        expect_rd(5'h05, 8'h11, "R9 event while gated");
        wr_evt(5'h04, 8'h01, 8'h00);
        tick();
        expect_irq(1'b1, "R8 irq after enable write");
        done = 1'b1;
        tick();
        finish_run();
    end
endmodule